// File: doc/BRIEF.md
# PLL Lock Monitor with Hysteresis

This block watches the two clocks that meet at a PLL's phase comparator: the divided reference and the divided feedback. Both are resynchronised into a fast sampling-clock domain. A rising edge on either one opens a measurement window. The next rising edge of the other one closes it. The number of sampling ticks between the two edges is the phase error of that pair, so the resolution is one sampling period.

Each completed measurement updates a single loss-of-lock flag with hysteresis. A large error sets the flag. Only a clearly smaller error clears it. Errors in the band between the two levels leave the flag as it was. If the closing edge never arrives, a timeout ends the window and counts as a large error, so a dead clock is flagged. The tick count and which clock led are also presented for debug.

Thresholds and timeout are parameters given in sampling ticks. SET_TICKS must exceed CLR_TICKS, and TIMEOUT_TICKS must exceed SET_TICKS.

Top module: `lock_monitor`

## Requirements
- R1: While rst_n is low and after it is released, `lock_lost` is 1, and it stays 1 until a measurement below CLR_TICKS completes.
- R2: A measurement is the count of sampling ticks from a rising edge on one input to the next rising edge on the other input. It is reported on `err_ticks` in the cycle `meas_done` pulses high. Rising edges that coincide in the same tick give 0.
- R3: `fb_first` is 1 when the feedback edge opened the window. It is 0 when the reference edge opened it or when the two edges coincided.
- R4: A measurement greater than SET_TICKS drives `lock_lost` to 1.
- R5: A measurement smaller than CLR_TICKS drives `lock_lost` to 0.
- R6: A measurement from CLR_TICKS to SET_TICKS inclusive leaves `lock_lost` unchanged.
- R7: `lock_lost` changes only in a cycle in which `meas_done` is 1.
- R8: If a window stays open for TIMEOUT_TICKS ticks without its closing edge, a measurement completes with `err_ticks` equal to TIMEOUT_TICKS, and `lock_lost` becomes 1.
- R9: While a window is open, further rising edges of the input that opened it are ignored. The window is closed only by the other input or by the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, the time base of every measurement |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div | input | 1 | Divided reference clock, asynchronous to clk |
| fb_div | input | 1 | Divided feedback clock, asynchronous to clk |
| lock_lost | output | 1 | Loss-of-lock flag with hysteresis, 1 = not locked |
| err_ticks | output | CW | Magnitude of the last measurement in ticks, CW = $clog2(TIMEOUT_TICKS+1) |
| fb_first | output | 1 | Last measurement had the feedback edge leading |
| meas_done | output | 1 | One-cycle pulse when a measurement completes |

## Verification
The assertions assume that the two divided clocks are much slower than the sampling clock, so that each synchronised level lasts several ticks and no edge is lost. They also assume that the parameters respect the ordering CLR_TICKS < SET_TICKS < TIMEOUT_TICKS; the timeout assertion depends on that ordering. The stimulus uses 40 ns clock periods against a 1 ns sampling clock. Every input edge is placed half a sampling period away from a sampling edge, so each skew of 0 to 6 ns is measured as an exact tick count with no quantisation doubt. Skews stay far below half the divided period, so edge pairing is never ambiguous except in the missing-clock scenario. That scenario checks the ambiguous pairing on purpose.

// File: rtl/lock_monitor.sv
`timescale 1ns/1ps
module lock_monitor #(
  parameter int SET_TICKS     = 4,
  parameter int CLR_TICKS     = 2,
  parameter int TIMEOUT_TICKS = 64,
  localparam int CW = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_div,
  input  logic          fb_div,
  output logic          lock_lost,
  output logic [CW-1:0] err_ticks,
  output logic          fb_first,
  output logic          meas_done
);

  localparam logic [CW-1:0] SET_L = CW'(SET_TICKS);
  localparam logic [CW-1:0] CLR_L = CW'(CLR_TICKS);
  localparam logic [CW-1:0] TMO_L = CW'(TIMEOUT_TICKS);

  typedef enum logic [1:0] {IDLE, WAIT_FB, WAIT_REF} state_t;

  state_t        st;
  logic [2:0]    ref_sh, fb_sh;
  logic [CW-1:0] cnt;

  wire ref_rise = ref_sh[1] & ~ref_sh[2];
  wire fb_rise  = fb_sh[1]  & ~fb_sh[2];

  wire both_now = (st == IDLE) && ref_rise && fb_rise;
  wire closing  = ((st == WAIT_FB) && fb_rise) || ((st == WAIT_REF) && ref_rise);
  wire expired  = (st != IDLE) && !closing && (cnt == TMO_L);
  wire done     = both_now || closing || expired;

  logic [CW-1:0] done_val;
  always_comb begin
    if (both_now)     done_val = '0;
    else if (expired) done_val = TMO_L;
    else              done_val = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sh <= '0;
      fb_sh  <= '0;
    end else begin
      ref_sh <= {ref_sh[1:0], ref_div};
      fb_sh  <= {fb_sh[1:0], fb_div};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= IDLE;
      cnt <= '0;
    end else begin
      case (st)
        IDLE: begin
          if (ref_rise && !fb_rise) begin
            st  <= WAIT_FB;
            cnt <= CW'(1);
          end else if (fb_rise && !ref_rise) begin
            st  <= WAIT_REF;
            cnt <= CW'(1);
          end
        end
        default: begin
          if (closing || expired) begin
            st  <= IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_lost <= 1'b1;
      err_ticks <= '0;
      fb_first  <= 1'b0;
      meas_done <= 1'b0;
    end else begin
      meas_done <= done;
      if (done) begin
        err_ticks <= done_val;
        fb_first  <= (st == WAIT_REF);
        if (done_val > SET_L)      lock_lost <= 1'b1;
        else if (done_val < CLR_L) lock_lost <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lock_monitor_chk.sv
`timescale 1ns/1ps
module lock_monitor_chk #(
  parameter int SET_TICKS     = 4,
  parameter int CLR_TICKS     = 2,
  parameter int TIMEOUT_TICKS = 64,
  parameter int CW            = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lock_lost,
  input logic [CW-1:0] err_ticks,
  input logic          meas_done
);

  localparam logic [CW-1:0] SET_L = CW'(SET_TICKS);
  localparam logic [CW-1:0] CLR_L = CW'(CLR_TICKS);
  localparam logic [CW-1:0] TMO_L = CW'(TIMEOUT_TICKS);

  a_r1_reset_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> lock_lost);

  a_r4_set_on_large: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_lost) |-> (meas_done && err_ticks > SET_L));

  a_r5_clear_on_small: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_lost) |-> (meas_done && err_ticks < CLR_L));

  a_r6_hold_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && err_ticks >= CLR_L && err_ticks <= SET_L) |-> $stable(lock_lost));

  a_r7_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |-> $stable(lock_lost));

  a_r8_bounded_error: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |-> err_ticks <= TMO_L);

  a_r2_done_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> !meas_done);

endmodule

bind lock_monitor lock_monitor_chk #(
  .SET_TICKS(SET_TICKS), .CLR_TICKS(CLR_TICKS),
  .TIMEOUT_TICKS(TIMEOUT_TICKS), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_lost(lock_lost),
  .err_ticks(err_ticks), .meas_done(meas_done)
);

// File: tb/lock_monitor_tb.sv
`timescale 1ns/1ps
module lock_monitor_tb;
  localparam real CLK_PERIOD = 1.0;
  localparam int  HALF       = 20;
  localparam int  SET_T      = 4;
  localparam int  CLR_T      = 2;
  localparam int  TMO        = 64;
  localparam int  CW         = $clog2(TMO + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_div = 1'b0;
  logic          fb_div = 1'b0;
  logic          lock_lost;
  logic [CW-1:0] err_ticks;
  logic          fb_first;
  logic          meas_done;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_flag = 1;
  bit finished = 0;

  lock_monitor #(.SET_TICKS(SET_T), .CLR_TICKS(CLR_T), .TIMEOUT_TICKS(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .fb_div(fb_div),
    .lock_lost(lock_lost), .err_ticks(err_ticks), .fb_first(fb_first),
    .meas_done(meas_done)
  );

  initial forever #(CLK_PERIOD / 2.0) clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_period(int skew);
    int s;
    s = (skew < 0) ? -skew : skew;
    if (skew >= 0) begin
      ref_div = 1'b1; #(s); fb_div = 1'b1; #(HALF - s);
      ref_div = 1'b0; #(s); fb_div = 1'b0; #(HALF - s);
    end else begin
      fb_div = 1'b1; #(s); ref_div = 1'b1; #(HALF - s);
      fb_div = 1'b0; #(s); ref_div = 1'b0; #(HALF - s);
    end
  endtask

  task automatic apply(int skew, string req);
    int a;
    a = (skew < 0) ? -skew : skew;
    drive_period(skew);
    if (a > SET_T) exp_flag = 1;
    else if (a < CLR_T) exp_flag = 0;
    check({req, " flag"}, int'(lock_lost), exp_flag);
    check("R2 err_ticks", int'(err_ticks), a);
    check("R3 fb_first", int'(fb_first), (skew < 0) ? 1 : 0);
  endtask

  task automatic t_reset;
    #10;
    check("R1 flag in reset", int'(lock_lost), 1);
    check("R2 no meas in reset", int'(meas_done), 0);
    rst_n = 1'b1;
    #10;
    check("R1 flag after release", int'(lock_lost), 1);
    exp_flag = 1;
  endtask

  task automatic t_band_before_lock;
    apply(3, "R1 band keeps reset flag");
    apply(2, "R6 clear edge value holds");
  endtask

  task automatic t_lock_and_band;
    apply(0, "R5 zero skew clears");
    apply(3, "R6 band keeps clear");
    apply(4, "R6 set edge value holds");
  endtask

  task automatic t_set_and_release;
    apply(5, "R4 large skew sets");
    apply(3, "R6 band keeps set");
    apply(2, "R6 lower edge keeps set");
    apply(1, "R5 small skew clears");
  endtask

  task automatic t_sweep;
    for (int s = 0; s <= 6; s++) apply(s, "R4 sweep up");
    for (int s = 6; s >= 0; s--) apply(s, "R5 sweep down");
  endtask

  task automatic t_fb_leads;
    apply(-3, "R6 fb leads band");
    apply(-5, "R4 fb leads large");
    apply(-1, "R5 fb leads small");
  endtask

  task automatic t_missing_fb;
    for (int i = 0; i < 3; i++) begin
      ref_div = 1'b1; #(HALF); ref_div = 1'b0; #(HALF);
    end
    check("R8 timeout sets flag", int'(lock_lost), 1);
    check("R8 timeout value", int'(err_ticks), TMO);
    drive_period(0);
    check("R9 window closed by other input", int'(err_ticks), 2 * HALF);
    check("R9 flag after long pairing", int'(lock_lost), 1);
    drive_period(0);
    check("R5 recovery clears", int'(lock_lost), 0);
    exp_flag = 0;
  endtask

  task automatic t_quiet;
    #50;
    check("R7 no edges no change", int'(lock_lost), exp_flag);
    check("R7 no pulse when idle", int'(meas_done), 0);
  endtask

  initial begin
    t_reset();
    t_band_before_lock();
    t_lock_and_band();
    t_set_and_release();
    t_sweep();
    t_fb_leads();
    t_missing_fb();
    t_quiet();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * CLK_PERIOD);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule